// File: doc/BRIEF.md
# Soft Mute with Long-Mute Zero Detect

This block sits in the sample path of a multi-channel DAC and softens the effect of a mute request. While samples flow unmuted, each channel output follows its input sample, one new value per sample strobe. When the mute request is raised, each channel stops tracking its input. Instead it decays toward mid-scale, starting from the value it last held. On every sample strobe the channel removes 1/64 of its current level, which gives a time constant of roughly 64 samples.

A single mute request covers every channel. A duration counter counts the sample strobes seen while mute is held. Once mute has lasted the configured number of samples (1024 by default) and zero detect is enabled, every channel output is forced exactly to mid-scale. A flag reports the forced state, and an active-low indicator reports it as well. Releasing mute clears the counter. The next strobe loads the current input sample directly, with no ramp back up.

Top module: `soft_mute_zd`

## Requirements
- R1: After reset all channel outputs are 0 (mid-scale), `force_mid` is 0 and `detect_n` is 1.
- R2: On a sample strobe with `mute_req` low, each channel output becomes that channel's 24-bit signed input sample on the next clock.
- R3: Between sample strobes the channel outputs do not change.
- R4: On a sample strobe with `mute_req` high and no forcing, each channel value y becomes y - (y >>> 6) (arithmetic shift), starting from the value held when mute began.
- R5: `force_mid` is 1 exactly when `zd_en` is 1 and at least 1024 consecutive sample strobes have occurred with `mute_req` high; while it is 1 every channel output reads 0.
- R6: `detect_n` is active low: it is 0 when zero detect has occurred (`force_mid` 1) and 1 otherwise.
- R7: One clock edge after `mute_req` is seen low, the mute duration count is 0, so `force_mid` is 0. The first unmuted strobe loads the current input without any ramp.
- R8: With `zd_en` low, `force_mid` stays 0 and `detect_n` stays 1 regardless of mute length, and the decay of R4 continues.
- R9: The mute duration count saturates at 1024, so forcing persists for any mute longer than 1024 strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle sample strobe |
| mute_req | input | 1 | Mute request, common to all channels |
| zd_en | input | 1 | Zero-detect enable |
| din | input | NUM_CH*DATA_W | Input samples, channel k in bits [k*DATA_W +: DATA_W], signed |
| dout | output | NUM_CH*DATA_W | Output samples, same packing |
| force_mid | output | 1 | High while outputs are forced to mid-scale |
| detect_n | output | 1 | Active-low zero-detect indicator |

## Verification
The bench builds the block with three channels, 24-bit samples, a shift of 6 and a hold threshold of 1024. With these values, full-scale positive and negative samples, the 1023/1024 threshold boundary and saturation beyond it can all be reached within a few thousand cycles. A third channel shows that one mute request drives all lanes alike. Toggling `zd_en` during a long mute covers the immediate assertion and release of forcing.

// File: rtl/smz_pkg.sv
package smz_pkg;
   // Width needed to hold the value lim inclusive
   function automatic int unsigned cnt_width(input int unsigned lim);
      return $clog2(lim + 1);
   endfunction
endpackage

// File: rtl/smz_lane.sv
module smz_lane #(
   parameter int unsigned DATA_W = 24,
   parameter int unsigned SHIFT  = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     stb,
   input  logic                     mute,
   input  logic                     force_mid,
   input  logic signed [DATA_W-1:0] din,
   output logic signed [DATA_W-1:0] y
);
   if (SHIFT < 1 || SHIFT >= DATA_W) begin : g_bad_shift
      $error("smz_lane: SHIFT must lie in 1..DATA_W-1");
   end

   logic signed [DATA_W-1:0] step;
   always_comb step = y - (y >>> SHIFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         y <= '0;
      else if (stb) begin
         if (!mute)       y <= din;
         else if (force_mid) y <= '0;
         else             y <= step;
      end
   end

   // R2
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !mute) |=> (y == $past(din)));
   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(y));
endmodule

// File: rtl/smz_mute_timer.sv
module smz_mute_timer #(
   parameter int unsigned HOLD  = 1024,
   parameter int unsigned CNT_W = smz_pkg::cnt_width(HOLD)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic mute,
   output logic reached
);
   if (HOLD < 1) begin : g_bad_hold
      $error("smz_mute_timer: HOLD must be at least 1");
   end

   localparam logic [CNT_W-1:0] LIM = CNT_W'(HOLD);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (!mute)              cnt <= '0;
      else if (stb && cnt != LIM)  cnt <= cnt + 1'b1;
   end

   assign reached = (cnt == LIM);

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIM);
   // R7
   mute_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mute |=> (cnt == '0));
endmodule

// File: rtl/soft_mute_zd.sv
module soft_mute_zd #(
   parameter int unsigned NUM_CH   = 2,
   parameter int unsigned DATA_W   = 24,
   parameter int unsigned SHIFT    = 6,
   parameter int unsigned HOLD     = 1024,
   parameter bit          FORCE_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smp_stb,
   input  logic                     mute_req,
   input  logic                     zd_en,
   input  logic [NUM_CH*DATA_W-1:0] din,
   output logic [NUM_CH*DATA_W-1:0] dout,
   output logic                     force_mid,
   output logic                     detect_n
);
   localparam int unsigned CNT_W = smz_pkg::cnt_width(HOLD);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("soft_mute_zd: NUM_CH must be at least 1");
   end

   logic reached;

   if (FORCE_EN) begin : g_zd
      smz_mute_timer #(.HOLD(HOLD), .CNT_W(CNT_W)) u_timer (
         .clk(clk), .rst_n(rst_n), .stb(smp_stb), .mute(mute_req),
         .reached(reached));
      assign force_mid = zd_en & reached;
   end else begin : g_no_zd
      assign reached   = 1'b0;
      assign force_mid = 1'b0;
   end

   assign detect_n = ~force_mid;

   for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
      logic signed [DATA_W-1:0] y;
      smz_lane #(.DATA_W(DATA_W), .SHIFT(SHIFT)) u_lane (
         .clk(clk), .rst_n(rst_n), .stb(smp_stb), .mute(mute_req),
         .force_mid(force_mid), .din(din[k*DATA_W +: DATA_W]), .y(y));
      assign dout[k*DATA_W +: DATA_W] = force_mid ? '0 : y;
   end

   // R5
   forced_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_mid |-> (dout == '0));
   // R8
   zd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !zd_en |-> detect_n);
endmodule

// File: tb/soft_mute_zd_bench.sv
module soft_mute_zd_bench;
   localparam int NCH = 3;
   localparam int DW  = 24;
   localparam int HLD = 1024;

   logic clk = 1'b0, rst_n = 1'b0, stb = 1'b0, mute = 1'b0, zd = 1'b0;
   logic [NCH*DW-1:0] din = '0;
   logic [NCH*DW-1:0] dout;
   logic force_mid, detect_n;

   always #2 clk = ~clk;

   soft_mute_zd #(.NUM_CH(NCH), .DATA_W(DW), .SHIFT(6), .HOLD(HLD)) u_soft_mute_zd (
      .clk(clk), .rst_n(rst_n), .smp_stb(stb), .mute_req(mute), .zd_en(zd),
      .din(din), .dout(dout), .force_mid(force_mid), .detect_n(detect_n));

   int checks = 0, fails = 0;
   string tag = "R1";
   int my [NCH];
   int mcnt = 0;
   int unsigned seed = 32'h1234_5678;

   function automatic int sx(input logic [DW-1:0] v);
      return int'($signed(v));
   endfunction

   // reference model: updated at each rising edge from pre-edge state
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NCH; k++) my[k] = 0;
         mcnt = 0;
      end else begin
         automatic bit frc = zd && (mcnt >= HLD);
         if (stb)
            for (int k = 0; k < NCH; k++) begin
               if (!mute)     my[k] = sx(din[k*DW +: DW]);
               else if (frc)  my[k] = 0;
               else           my[k] = my[k] - (my[k] >>> 6);
            end
         if (!mute) mcnt = 0;
         else if (stb && mcnt < HLD) mcnt = mcnt + 1;
      end
   end

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      automatic bit efrc = zd && (mcnt >= HLD);
      for (int k = 0; k < NCH; k++) begin
         automatic int exp_v = efrc ? 0 : my[k];
         checks++;
         if (sx(dout[k*DW +: DW]) != exp_v) begin
            fails++;
            $display("FAIL %s ch%0d dout=%0d exp=%0d", tag, k, sx(dout[k*DW +: DW]), exp_v);
         end
      end
      checks++;
      if (force_mid !== efrc) begin
         fails++;
         $display("FAIL %s/R5 force_mid=%0b exp=%0b", tag, force_mid, efrc);
      end
      checks++;
      if (detect_n !== !efrc) begin
         fails++;
         $display("FAIL %s/R6 detect_n=%0b exp=%0b", tag, detect_n, !efrc);
      end
   end

   function automatic logic [DW-1:0] nxt();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed[31:8];
   endfunction

   // one sample period: strobe cycle then an idle cycle (R3)
   task automatic sample(input logic [NCH*DW-1:0] d);
      @(negedge clk); din = d; stb = 1'b1;
      @(negedge clk); stb = 1'b0; din = ~d;
   endtask

   task automatic rnd_sample();
      logic [NCH*DW-1:0] d;
      for (int k = 0; k < NCH; k++) d[k*DW +: DW] = nxt();
      sample(d);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            // R2: varied patterns incl. full-scale extremes
            tag = "R2";
            sample({24'h7FFFFF, 24'h800000, 24'h000001});
            sample({24'hFFFFFF, 24'h400000, 24'hC00000});
            repeat (6) rnd_sample();
            sample({24'h7FFFFF, 24'h800000, 24'hFFFFC1});
            // R4: decay with zero detect on; R5 boundary at 1024; R9 saturation
            tag = "R4"; zd = 1'b1; mute = 1'b1;
            repeat (1023) rnd_sample();
            tag = "R5";
            repeat (4) rnd_sample();
            tag = "R9";
            repeat (40) rnd_sample();
            // R7: release, immediate reload
            tag = "R7"; @(negedge clk); mute = 1'b0;
            repeat (2) @(negedge clk);
            repeat (4) rnd_sample();
            // R8: zero detect off during long mute
            tag = "R8"; zd = 1'b0; mute = 1'b1;
            repeat (1100) rnd_sample();
            tag = "R5"; zd = 1'b1;
            repeat (3) rnd_sample();
            zd = 1'b0; repeat (2) rnd_sample();
            tag = "R7"; mute = 1'b0;
            repeat (3) rnd_sample();
            repeat (3) @(negedge clk);
         end
         begin
            repeat (20000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule